// File: doc/BRIEF.md
# Memory-mapped BCD calendar clock

This block keeps the time of day and the calendar in a set of running BCD counters that advance on a one-second tick. Once per second the counters are copied into seven byte-wide clock registers that sit at the top of a 15-bit byte address space, just above a control byte. Software reads and writes the clock registers exactly like the ordinary byte RAM that fills the lower addresses. All accesses use one synchronous port: `cs` with `we` high writes `wdata` at the clock edge, and `cs` with `we` low returns the addressed byte on `rdata` one clock later.

The control byte holds two hold bits and a six-bit calibration value. The read-hold bit freezes the copy so that a multi-byte read sees one coherent snapshot. The write-hold bit also freezes the copy so that software can compose a new time in the clock registers. Clearing it loads the clock registers into the counters. While the power-good input is low, every write is refused: RAM, control byte and clock bytes alike.

Top module: `bcd_rtc_map`

## Requirements
- R1: After reset the control byte reads 00h and the clock bytes read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00.
- R2: On each tick the seconds advance in BCD (09 becomes 10). 59 seconds wrap to 00 and carry into minutes, 59 minutes wrap to 00 and carry into hours, and hour 23 wraps to 00 and carries into the date.
- R3: The date wraps to 01 and the month advances after day 30 of months 04, 06, 09 and 11, and after day 31 of the other months except 02. Month 12 wraps to 01 and the year advances, and year 99 wraps to 00.
- R4: In month 02 the last day is 29 when the BCD year is divisible by 4 (00 and 24 included) and 28 otherwise.
- R5: The day of week advances with every date change, counting 01 to 07 and wrapping from 07 to 01.
- R6: The clock bytes are control 7FF8h, seconds 7FF9h, minutes 7FFAh, hours 7FFBh, day of week 7FFCh, date 7FFDh, month 7FFEh and year 7FFFh. One clock after the tick advances the counters, the counters are copied into these bytes when both hold bits are clear. A read returns the addressed byte on `rdata` in the cycle after `cs` is sampled with `we` low.
- R7: While control bit 6 (read-hold) is set, ticks do not change the clock bytes, but the counters keep counting. The first copy after the bit clears shows every tick that arrived during the hold.
- R8: While control bit 7 (write-hold) is set, no copy takes place and values written to clock bytes remain readable. A control write that clears bit 7 while it is set loads the clock bytes into the counters.
- R9: Control bits 5:0 are stored and read back unchanged, and they have no effect on counting.
- R10: While `pwr_ok` is low, writes to the RAM, the control byte and the clock bytes have no effect.
- R11: Addresses below 7FF8h read back the byte last written to them (the RAM holds 2^RAM_AW bytes, indexed by the low address bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply good; writes are refused while low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| cs | input | 1 | Access strobe |
| we | input | 1 | 1 = write, 0 = read, qualified by cs |
| addr | input | ADDR_W (15) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The hard states to reach are the calendar boundaries: Dec 31 of year 99, the end of February in leap and common years, and the end of 30-day months. Ticking there from reset would take months of simulated seconds. The bench instead uses the write-hold path: it sets bit 7, writes a time one second before each boundary, clears bit 7 to load the counters, and then gives a single tick. The hold tests count ticks that arrive while the copy is frozen. They then show that these ticks were not lost once the copy resumes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Packed so that clock byte k (1..7) is bits [8*(k-1) +: 8].
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int unsigned FIELDS = 7;
  localparam logic [55:0] RTC_RESET = 56'h00_01_01_01_00_00_00;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Value 10*t + u is divisible by 4 when (2*t + u) mod 4 == 0.
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t rtc_advance(input rtc_time_t t);
    rtc_time_t n;
    logic c_min, c_hr, c_day, c_mon, c_yr;
    c_min = (t.sec  >= 8'h59);
    c_hr  = c_min && (t.mins >= 8'h59);
    c_day = c_hr  && (t.hrs  >= 8'h23);
    c_mon = c_day && (t.mday >= month_days(t.mon, bcd_leap(t.yr)));
    c_yr  = c_mon && (t.mon  >= 8'h12);
    n.sec  = c_min ? 8'h00 : bcd_inc(t.sec);
    n.mins = c_min ? (c_hr ? 8'h00 : bcd_inc(t.mins)) : t.mins;
    n.hrs  = c_hr  ? (c_day ? 8'h00 : bcd_inc(t.hrs)) : t.hrs;
    n.wday = c_day ? ((t.wday >= 8'h07) ? 8'h01 : bcd_inc(t.wday)) : t.wday;
    n.mday = c_day ? (c_mon ? 8'h01 : bcd_inc(t.mday)) : t.mday;
    n.mon  = c_mon ? (c_yr ? 8'h01 : bcd_inc(t.mon)) : t.mon;
    n.yr   = c_yr  ? ((t.yr >= 8'h99) ? 8'h00 : bcd_inc(t.yr)) : t.yr;
    return n;
  endfunction

endpackage

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[a] <= d;
  end

  assign q = mem[a];
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt,
  output logic      day_roll
);
  rtc_time_t nxt;

  assign nxt = rtc_advance(cnt);

  // Event: this tick moves the calendar to the next day.
  assign day_roll = tick && !load && (cnt.sec >= 8'h59) &&
                    (cnt.mins >= 8'h59) && (cnt.hrs >= 8'h23);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= RTC_RESET;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= nxt;
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  widx,
  input  logic [7:0]  wdata,
  input  logic        copy_req,
  input  rtc_time_t   cnt,
  output logic [55:0] shadow,
  output logic [7:0]  ctrl,
  output logic        copy_evt,
  output logic        load_evt
);
  localparam int unsigned WHOLD = 7;
  localparam int unsigned RHOLD = 6;

  assign copy_evt = copy_req && !ctrl[WHOLD] && !ctrl[RHOLD];
  assign load_evt = wr_en && (widx == 3'd0) && ctrl[WHOLD] && !wdata[WHOLD];

  always_ff @(posedge clk) begin
    if (!rst_n)                           ctrl <= 8'h00;
    else if (wr_en && (widx == 3'd0))     ctrl <= wdata;
  end

  for (genvar k = 1; k <= FIELDS; k++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 q <= RTC_RESET[8*(k-1) +: 8];
      else if (wr_en && (widx == 3'(k)))          q <= wdata;
      else if (copy_evt)                          q <= cnt[8*(k-1) +: 8];
    end
    assign shadow[8*(k-1) +: 8] = q;
  end
endmodule

// File: rtl/bcd_rtc_map.sv
module bcd_rtc_map
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              tick_1hz,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int unsigned HI_W = ADDR_W - 3;

  logic        in_clk, wr_ok, wr_clk, wr_ram, rd_en;
  logic        tick_adv, tick_d, copy_evt, load_evt, day_roll;
  logic [2:0]  idx;
  logic [7:0]  ctrl_q, ram_q;
  logic [55:0] shadow;
  rtc_time_t   cnt, shadow_t;
  logic [7:0]  view [8];

  assign in_clk   = (addr[ADDR_W-1:3] == {HI_W{1'b1}});
  assign idx      = addr[2:0];
  assign wr_ok    = pwr_ok && cs && we;
  assign wr_clk   = wr_ok && in_clk;
  assign wr_ram   = wr_ok && !in_clk;
  assign rd_en    = cs && !we;
  assign tick_adv = tick_1hz;
  assign shadow_t = shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_d <= 1'b0;
    else        tick_d <= tick_adv;
  end

  rtc_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_adv),
    .load     (load_evt),
    .load_val (shadow_t),
    .cnt      (cnt),
    .day_roll (day_roll)
  );

  rtc_shadow u_shd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_clk),
    .widx     (idx),
    .wdata    (wdata),
    .copy_req (tick_d),
    .cnt      (cnt),
    .shadow   (shadow),
    .ctrl     (ctrl_q),
    .copy_evt (copy_evt),
    .load_evt (load_evt)
  );

  rtc_ram #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk (clk),
    .wr  (wr_ram),
    .a   (addr[RAM_AW-1:0]),
    .d   (wdata),
    .q   (ram_q)
  );

  assign view[0] = ctrl_q;
  for (genvar k = 1; k < 8; k++) begin : g_view
    assign view[k] = shadow[8*(k-1) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= in_clk ? view[idx] : ram_q;
  end
endmodule

// File: rtl/rtc_map_chk.sv
module rtc_map_chk
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_ok,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic [7:0]        ctrl_q,
  input logic [55:0]       shadow,
  input rtc_time_t         cnt,
  input logic              tick_adv,
  input logic              copy_evt,
  input logic              load_evt,
  input logic              day_roll,
  input logic              wr_ok
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}} - ADDR_W'(7);

  a_r10_no_write_power_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok && !copy_evt) |=> ($stable(ctrl_q) && $stable(shadow)));

  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q[7] || ctrl_q[6]) && !wr_ok) |=> $stable(shadow));

  a_r6_copy_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_evt && !wr_ok) |=> (shadow == $past(cnt)));

  a_r8_load_counters: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt == $past(shadow)));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_adv && !load_evt && cnt.sec == 8'h59) |=> (cnt.sec == 8'h00));

  a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && cnt.wday == 8'h07) |=> (cnt.wday == 8'h01));

  a_r6_read_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == CTRL_ADDR) |=> (rdata == $past(ctrl_q)));
endmodule

bind bcd_rtc_map rtc_map_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_ok   (pwr_ok),
  .cs       (cs),
  .we       (we),
  .addr     (addr),
  .rdata    (rdata),
  .ctrl_q   (ctrl_q),
  .shadow   (shadow),
  .cnt      (cnt),
  .tick_adv (tick_adv),
  .copy_evt (copy_evt),
  .load_evt (load_evt),
  .day_roll (day_roll),
  .wr_ok    (wr_ok)
);

// File: tb/bcd_rtc_map_tb.sv
`timescale 1ns/1ps
module bcd_rtc_map_tb;
  localparam logic [14:0] A_CTL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                          A_HR = 15'h7FFB, A_WD = 15'h7FFC, A_MD = 15'h7FFD,
                          A_MO = 15'h7FFE, A_YR = 15'h7FFF;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1, tick_1hz = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bcd_rtc_map u_dut (.clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tick_1hz(tick_1hz),
    .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    @(negedge clk); cs = 0; d = rdata;
  endtask

  task automatic rd_check(input string tag, input logic [14:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
    @(negedge clk);
  endtask

  // Write-hold, compose the time, release to load the counters.
  task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y);
    wr(A_CTL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_WD, wd);
    wr(A_MD, md); wr(A_MO, mo); wr(A_YR, y);
    wr(A_CTL, 8'h00);
  endtask

  task automatic roll(input string tag, input logic [7:0] s, mi, h, wd, md, mo, y,
                      input logic [7:0] es, emi, eh, ewd, emd, emo, ey);
    set_time(s, mi, h, wd, md, mo, y);
    tick();
    rd_check({tag, " sec"}, A_SEC, es);
    rd_check({tag, " min"}, A_MIN, emi);
    rd_check({tag, " hour"}, A_HR, eh);
    rd_check({tag, " wday"}, A_WD, ewd);
    rd_check({tag, " date"}, A_MD, emd);
    rd_check({tag, " month"}, A_MO, emo);
    rd_check({tag, " year"}, A_YR, ey);
  endtask

  task automatic t_reset();
    rd_check("R1 ctrl", A_CTL, 8'h00);
    rd_check("R1 sec", A_SEC, 8'h00);
    rd_check("R1 hour", A_HR, 8'h00);
    rd_check("R1 wday", A_WD, 8'h01);
    rd_check("R1 date", A_MD, 8'h01);
    rd_check("R1 month", A_MO, 8'h01);
    rd_check("R1 year", A_YR, 8'h00);
  endtask

  task automatic t_time_roll();
    roll("R2 nibble", 8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00,
                      8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    roll("R2 hour", 8'h59, 8'h59, 8'h12, 8'h03, 8'h15, 8'h06, 8'h23,
                    8'h00, 8'h00, 8'h13, 8'h03, 8'h15, 8'h06, 8'h23);
    roll("R2 midnight", 8'h59, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h23,
                        8'h00, 8'h00, 8'h00, 8'h04, 8'h16, 8'h06, 8'h23);
  endtask

  task automatic t_month_end();
    roll("R3 apr30", 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23,
                     8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h23);
    roll("R3 jan30", 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h23,
                     8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h01, 8'h23);
    roll("R3 dec31y99", 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99,
                        8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_february();
    roll("R4 leap24 28", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24,
                         8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h24);
    roll("R4 leap24 29", 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24,
                         8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h24);
    roll("R4 common23", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23,
                        8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23);
    roll("R4 leap00", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00,
                      8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00);
  endtask

  task automatic t_wday();
    roll("R5 wrap", 8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h23,
                    8'h00, 8'h00, 8'h00, 8'h01, 8'h11, 8'h03, 8'h23);
  endtask

  task automatic t_read_hold();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_CTL, 8'h40);
    tick();
    rd_check("R7 frozen", A_SEC, 8'h10);
    wr(A_CTL, 8'h00);
    rd_check("R7 still", A_SEC, 8'h10);
    tick();
    rd_check("R7 resumed", A_SEC, 8'h12);
  endtask

  task automatic t_write_hold();
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_CTL, 8'h80);
    tick();
    rd_check("R8 no copy", A_SEC, 8'h20);
    wr(A_SEC, 8'h30);
    rd_check("R8 written", A_SEC, 8'h30);
    tick();
    rd_check("R8 kept", A_SEC, 8'h30);
    wr(A_CTL, 8'h00);
    tick();
    rd_check("R8 loaded", A_SEC, 8'h31);
  endtask

  task automatic t_calib();
    set_time(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_CTL, 8'h2A);
    rd_check("R9 readback", A_CTL, 8'h2A);
    tick();
    rd_check("R9 counting", A_SEC, 8'h41);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_ram();
    wr(15'h0005, 8'hA5);
    wr(15'h0010, 8'h3C);
    rd_check("R11 ram5", 15'h0005, 8'hA5);
    rd_check("R11 ram10", 15'h0010, 8'h3C);
  endtask

  task automatic t_power();
    logic [7:0] s0;
    rd(A_SEC, s0);
    pwr_ok = 0;
    wr(15'h0005, 8'h5A);
    wr(A_CTL, 8'h40);
    wr(A_SEC, 8'h77);
    pwr_ok = 1;
    rd_check("R10 ram", 15'h0005, 8'hA5);
    rd_check("R10 ctrl", A_CTL, 8'h00);
    rd_check("R10 sec", A_SEC, s0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_time_roll();
    t_month_end();
    t_february();
    t_wday();
    t_read_hold();
    t_write_hold();
    t_calib();
    t_ram();
    t_power();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule